// File: doc/BRIEF.md
# Burst Bus Cycle Controller

This block sequences the cycles of an external multiplexed address/data bus on behalf of a 32-bit processor core. The core hands over one access at a time: a start address, a direction, a length of one to four words, the write words of the whole burst, and a flag that opens an atomic read-modify-write pair. The controller places the address on the shared lines for one cycle, then runs one data beat per word. A single active-low ready/recover input inserts wait states during data beats. After a read, the same input stretches a recovery cycle until it is sampled high. Each read beat that completes returns its word to the core through a one-cycle response pulse.

An active-low last-beat strobe marks the final word of every access. An active-low lock output covers an atomic pair: it opens on the address cycle of the flagged access and releases in the final beat of the access that follows. An external master can take the bus with a hold request. The controller answers with a hold acknowledge and floats its address/data and control drivers, but only at a bus-idle point. It never grants while the lock is held. Hold requests are also served while reset is applied.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: `bus_state` encodes idle=0, address=1, data=2, wait=3, recovery=4, hold=5. A request captured from idle enters address on the next cycle and data on the cycle after.
- R2: In a data or wait cycle with `rdy_n` sampled high, the next cycle is wait and all bus outputs keep their values. With `rdy_n` sampled low, the beat completes.
- R3: Every read beat completed at a clock edge raises `rsp_valid` for the following cycle, with `rsp_data` equal to `ad_in` as sampled at that edge. Write beats raise no response.
- R4: A read access always ends in recovery, which repeats while `rdy_n` is sampled low. A write access leaves its last beat directly for idle, or for address if a request is waiting.
- R5: `blast_n` is low exactly in the data and wait cycles of the final beat of an access, for lengths 1 to 4 (`req_len` holds words minus one).
- R6: `lock_n` goes low in the address cycle of an access flagged atomic when no lock is held. It stays low until the final beat of the next access begins, and is high during that beat.
- R7: `hold` is sampled only in idle, or in recovery once recovery is complete, and only while no lock is held. When it is accepted, the next cycle is hold, with `holda`=1, `ctl_oe`=0 and `ad_oe`=0. Hold takes priority over a waiting request.
- R8: When `hold` is sampled low in the hold state, `holda` drops and `ctl_oe` returns to 1 on the next cycle. The state becomes address if `req_valid` was high, otherwise idle.
- R9: While `rst_n` is low, the state is idle with all strobes inactive, `ctl_oe`=1 and `holda`=0. If `hold` is high, the state is hold with `holda`=1 and `ctl_oe`=0.
- R10: `ad_oe` is 1 with `ad_out` equal to the address in the address cycle. During the data and wait cycles of a write, `ad_oe` is 1 and `ad_out` carries word k of `req_wdata` (bits 32k+31..32k) in beat k. Otherwise `ad_oe` is 0.
- R11: A request is captured at an edge where `req_valid` is high in idle, in completed recovery, at the end of a write, or when hold is released. In the cycle after capture, `req_ack` and a low `ads_n` are present together with the address state, and `bus_wr` holds the captured direction until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present, held until acknowledged |
| req_ack | output | 1 | One-cycle pulse: request captured |
| req_addr | input | DW | Start address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LW | Number of words minus one |
| req_atomic | input | 1 | Opens an atomic pair with the next access |
| req_wdata | input | MAXB*DW | Write words, word k in bits 32k+31..32k |
| rsp_valid | output | 1 | Read word returned this cycle |
| rsp_data | output | DW | Returned read word |
| ad_out | output | DW | Multiplexed address/data driven value |
| ad_in | input | DW | Multiplexed address/data sampled value |
| ad_oe | output | 1 | Drive enable for the address/data lines |
| ctl_oe | output | 1 | Drive enable for the control lines |
| ads_n | output | 1 | Address strobe, low in the address cycle |
| bus_wr | output | 1 | Direction of the current access |
| blast_n | output | 1 | Last-beat strobe, active low |
| lock_n | output | 1 | Atomic lock, active low |
| rdy_n | input | 1 | Ready in data cycles, recover in recovery cycles, active low |
| hold | input | 1 | External master bus request |
| holda | output | 1 | Bus released to the external master |
| bus_state | output | 3 | Current bus state code |

## Verification
Every output is a register, so each result appears in the cycle after the edge that sampled its cause. A wait or a completed beat follows the `rdy_n` value of the previous cycle, and a response follows its completing beat by one cycle. `req_ack` comes with the address cycle, one cycle after capture, and `holda` comes one cycle after `hold` was seen at an allowed point. The bench keeps a behavioural model that is advanced on each rising edge from the same inputs the design sees. It compares every output against that model at the following falling edge, which lines up the expected and actual values in the same cycle. A device model drives `rdy_n` from the model's own state with chosen wait and recovery counts.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DATA  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_RECOV = 3'd4,
        ST_HOLD  = 3'd5
    } bus_st_e;
endpackage

// File: rtl/bcc_beat_buf.sv
module bcc_beat_buf #(
    parameter int DW   = 32,
    parameter int MAXB = 4,
    localparam int LW  = $clog2(MAXB)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 advance,
    input  logic [LW-1:0]        len,
    input  logic [MAXB*DW-1:0]   wdata,
    output logic [DW-1:0]        word,
    output logic [DW-1:0]        nxt_word,
    output logic                 last,
    output logic                 nxt_last
);
    typedef struct packed {
        logic [MAXB-1:0][DW-1:0] words;
        logic [LW-1:0]           cnt;
        logic [LW-1:0]           len;
    } buf_t;

    buf_t          buf_d, buf_q;
    logic [LW-1:0] nxt_idx;

    assign nxt_idx  = buf_q.cnt + 1'b1;
    assign word     = buf_q.words[buf_q.cnt];
    assign nxt_word = buf_q.words[nxt_idx];
    assign last     = (buf_q.cnt == buf_q.len);
    assign nxt_last = (nxt_idx == buf_q.len);

    always_comb begin
        buf_d = buf_q;
        if (load) begin
            buf_d.words = wdata;
            buf_d.cnt   = '0;
            buf_d.len   = len;
        end else if (advance) begin
            buf_d.cnt = nxt_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end
endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
    import bcc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [DW-1:0] req_addr,
    input  logic          req_write,
    input  logic          req_atomic,
    input  logic [DW-1:0] ad_in,
    input  logic          rdy_n,
    input  logic          hold,
    input  logic          buf_last,
    input  logic          buf_nxt_last,
    input  logic [DW-1:0] buf_word,
    input  logic [DW-1:0] buf_nxt_word,
    output logic          buf_load,
    output logic          buf_adv,
    output logic          req_ack,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic          ctl_oe,
    output logic          ads_n,
    output logic          bus_wr,
    output logic          blast_n,
    output logic          lock_n,
    output logic          holda,
    output logic [2:0]    bus_state
);
    typedef struct packed {
        bus_st_e       st;
        logic          write;
        logic          locked;
        logic          closing;
        logic          holda;
        logic          ctl_oe;
        logic          ad_oe;
        logic          ads_n;
        logic          blast_n;
        logic          rsp_valid;
        logic          ack;
        logic [DW-1:0] ad_out;
        logic [DW-1:0] rsp_data;
    } seq_t;

    seq_t seq_d, seq_q, seq_rst;
    logic take, to_hold, hold_ok;

    assign hold_ok = hold && !seq_q.locked;

    always_comb begin
        seq_rst         = '0;
        seq_rst.st      = hold ? ST_HOLD : ST_IDLE;
        seq_rst.ads_n   = 1'b1;
        seq_rst.blast_n = 1'b1;
        seq_rst.holda   = hold;
        seq_rst.ctl_oe  = !hold;
    end

    always_comb begin
        seq_d           = seq_q;
        seq_d.ack       = 1'b0;
        seq_d.rsp_valid = 1'b0;
        seq_d.ads_n     = 1'b1;
        take            = 1'b0;
        to_hold         = 1'b0;
        buf_adv         = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (hold_ok)        to_hold = 1'b1;
                else if (req_valid) take    = 1'b1;
            end
            ST_ADDR: begin
                seq_d.st      = ST_DATA;
                seq_d.blast_n = !buf_last;
                seq_d.ad_oe   = seq_q.write;
                seq_d.ad_out  = seq_q.write ? buf_word : '0;
                if (seq_q.closing && buf_last) seq_d.locked = 1'b0;
            end
            ST_DATA, ST_WAIT: begin
                if (rdy_n) begin
                    seq_d.st = ST_WAIT;
                end else begin
                    if (!seq_q.write) begin
                        seq_d.rsp_valid = 1'b1;
                        seq_d.rsp_data  = ad_in;
                    end
                    if (!seq_q.blast_n) begin
                        seq_d.blast_n = 1'b1;
                        seq_d.ad_oe   = 1'b0;
                        if (!seq_q.write)   seq_d.st = ST_RECOV;
                        else if (req_valid) take     = 1'b1;
                        else                seq_d.st = ST_IDLE;
                    end else begin
                        buf_adv       = 1'b1;
                        seq_d.st      = ST_DATA;
                        seq_d.blast_n = !buf_nxt_last;
                        seq_d.ad_out  = seq_q.write ? buf_nxt_word : '0;
                        if (seq_q.closing && buf_nxt_last) seq_d.locked = 1'b0;
                    end
                end
            end
            ST_RECOV: begin
                if (!rdy_n) begin
                    seq_d.st = ST_RECOV;
                end else if (hold_ok) begin
                    to_hold = 1'b1;
                end else if (req_valid) begin
                    take = 1'b1;
                end else begin
                    seq_d.st = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (!hold) begin
                    seq_d.holda  = 1'b0;
                    seq_d.ctl_oe = 1'b1;
                    if (req_valid) take     = 1'b1;
                    else           seq_d.st = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase

        if (to_hold) begin
            seq_d.st     = ST_HOLD;
            seq_d.holda  = 1'b1;
            seq_d.ctl_oe = 1'b0;
            seq_d.ad_oe  = 1'b0;
        end
        if (take) begin
            seq_d.st     = ST_ADDR;
            seq_d.ads_n  = 1'b0;
            seq_d.ad_oe  = 1'b1;
            seq_d.ad_out = req_addr;
            seq_d.write  = req_write;
            seq_d.ack    = 1'b1;
            if (seq_q.locked) begin
                seq_d.closing = 1'b1;
            end else begin
                seq_d.closing = 1'b0;
                seq_d.locked  = req_atomic;
            end
        end
        buf_load = take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= seq_rst;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ack   = seq_q.ack;
    assign rsp_valid = seq_q.rsp_valid;
    assign rsp_data  = seq_q.rsp_data;
    assign ad_out    = seq_q.ad_out;
    assign ad_oe     = seq_q.ad_oe;
    assign ctl_oe    = seq_q.ctl_oe;
    assign ads_n     = seq_q.ads_n;
    assign bus_wr    = seq_q.write;
    assign blast_n   = seq_q.blast_n;
    assign lock_n    = !seq_q.locked;
    assign holda     = seq_q.holda;
    assign bus_state = seq_q.st;
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl #(
    parameter int DW   = 32,
    parameter int MAXB = 4,
    localparam int LW  = $clog2(MAXB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ack,
    input  logic [DW-1:0]      req_addr,
    input  logic               req_write,
    input  logic [LW-1:0]      req_len,
    input  logic               req_atomic,
    input  logic [MAXB*DW-1:0] req_wdata,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_data,
    output logic [DW-1:0]      ad_out,
    input  logic [DW-1:0]      ad_in,
    output logic               ad_oe,
    output logic               ctl_oe,
    output logic               ads_n,
    output logic               bus_wr,
    output logic               blast_n,
    output logic               lock_n,
    input  logic               rdy_n,
    input  logic               hold,
    output logic               holda,
    output logic [2:0]         bus_state
);
    logic          buf_load, buf_adv, buf_last, buf_nxt_last;
    logic [DW-1:0] buf_word, buf_nxt_word;

    bcc_beat_buf #(.DW(DW), .MAXB(MAXB)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (buf_load),
        .advance  (buf_adv),
        .len      (req_len),
        .wdata    (req_wdata),
        .word     (buf_word),
        .nxt_word (buf_nxt_word),
        .last     (buf_last),
        .nxt_last (buf_nxt_last)
    );

    bcc_seq #(.DW(DW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .req_atomic   (req_atomic),
        .ad_in        (ad_in),
        .rdy_n        (rdy_n),
        .hold         (hold),
        .buf_last     (buf_last),
        .buf_nxt_last (buf_nxt_last),
        .buf_word     (buf_word),
        .buf_nxt_word (buf_nxt_word),
        .buf_load     (buf_load),
        .buf_adv      (buf_adv),
        .req_ack      (req_ack),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .ad_out       (ad_out),
        .ad_oe        (ad_oe),
        .ctl_oe       (ctl_oe),
        .ads_n        (ads_n),
        .bus_wr       (bus_wr),
        .blast_n      (blast_n),
        .lock_n       (lock_n),
        .holda        (holda),
        .bus_state    (bus_state)
    );
endmodule

// File: rtl/bcc_chk.sv
module bcc_chk
    import bcc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_state,
    input logic       blast_n,
    input logic       lock_n,
    input logic       holda,
    input logic       ctl_oe,
    input logic       ad_oe,
    input logic       ads_n,
    input logic       rdy_n,
    input logic       bus_wr,
    input logic       req_ack
);
    logic in_data;
    assign in_data = (bus_state == ST_DATA) || (bus_state == ST_WAIT);

    AST_WAIT_ON_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && rdy_n) |=> (bus_state == ST_WAIT)); // R2
    AST_READ_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !rdy_n && !blast_n && !bus_wr) |=> (bus_state == ST_RECOV)); // R4
    AST_RECOV_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_RECOV && !rdy_n) |=> (bus_state == ST_RECOV)); // R4
    AST_BLAST_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !blast_n |-> in_data); // R5
    AST_NO_GRANT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        holda |-> lock_n); // R7
    AST_HOLDA_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        holda |-> (!ctl_oe && !ad_oe && bus_state == ST_HOLD)); // R7
    AST_ACK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (bus_state == ST_ADDR && !ads_n && ad_oe)); // R11
endmodule

bind bus_cycle_ctrl bcc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_state (bus_state),
    .blast_n   (blast_n),
    .lock_n    (lock_n),
    .holda     (holda),
    .ctl_oe    (ctl_oe),
    .ad_oe     (ad_oe),
    .ads_n     (ads_n),
    .rdy_n     (rdy_n),
    .bus_wr    (bus_wr),
    .req_ack   (req_ack)
);

// File: tb/bus_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ack;
    logic [31:0]  req_addr = '0;
    logic         req_write = 1'b0;
    logic [1:0]   req_len = '0;
    logic         req_atomic = 1'b0;
    logic [127:0] req_wdata = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_data;
    logic [31:0]  ad_out;
    logic [31:0]  ad_in = '0;
    logic         ad_oe, ctl_oe, ads_n, bus_wr, blast_n, lock_n, holda;
    logic         rdy_n = 1'b1;
    logic         hold = 1'b0;
    logic [2:0]   bus_state;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_cycle_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
        .req_addr(req_addr), .req_write(req_write), .req_len(req_len),
        .req_atomic(req_atomic), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe),
        .ctl_oe(ctl_oe), .ads_n(ads_n), .bus_wr(bus_wr), .blast_n(blast_n),
        .lock_n(lock_n), .rdy_n(rdy_n), .hold(hold), .holda(holda),
        .bus_state(bus_state)
    );

    // ---------------- behavioural reference model ----------------
    int          m_st = 0, m_beat = 0, m_len = 0;
    bit          m_wr, m_lk, m_cl, m_ha, m_coe = 1'b1, m_aoe, m_ads_n = 1'b1;
    bit          m_bl_n = 1'b1, m_rv, m_ack, take, toh;
    logic [31:0] m_ad = '0, m_rd = '0;
    logic [31:0] m_words [4];

    always @(posedge clk) begin
        m_rv = 0; m_ack = 0; m_ads_n = 1; take = 0; toh = 0;
        if (!rst_n) begin
            m_st = hold ? 5 : 0; m_ha = hold; m_coe = !hold; m_aoe = 0;
            m_bl_n = 1; m_lk = 0; m_cl = 0; m_wr = 0; m_ad = '0; m_rd = '0;
        end else begin
            case (m_st)
                0: if (hold && !m_lk) toh = 1; else if (req_valid) take = 1;
                1: begin
                    m_st = 2; m_beat = 0; m_bl_n = (m_len != 0); m_aoe = m_wr;
                    m_ad = m_wr ? m_words[0] : '0;
                    if (m_cl && m_len == 0) m_lk = 0;
                end
                2, 3: if (rdy_n) m_st = 3;
                    else begin
                        if (!m_wr) begin m_rv = 1; m_rd = ad_in; end
                        if (m_beat == m_len) begin
                            m_bl_n = 1; m_aoe = 0;
                            if (!m_wr) m_st = 4; else if (req_valid) take = 1; else m_st = 0;
                        end else begin
                            m_beat++; m_st = 2; m_bl_n = (m_beat != m_len);
                            m_ad = m_wr ? m_words[m_beat] : '0;
                            if (m_cl && m_beat == m_len) m_lk = 0;
                        end
                    end
                4: if (rdy_n) begin
                    if (hold && !m_lk) toh = 1; else if (req_valid) take = 1; else m_st = 0;
                end
                5: if (!hold) begin
                    m_ha = 0; m_coe = 1;
                    if (req_valid) take = 1; else m_st = 0;
                end
                default: m_st = 0;
            endcase
            if (toh) begin m_st = 5; m_ha = 1; m_coe = 0; m_aoe = 0; end
            if (take) begin
                m_st = 1; m_ads_n = 0; m_aoe = 1; m_ad = req_addr; m_wr = req_write;
                m_ack = 1; m_len = int'(req_len);
                for (int k = 0; k < 4; k++) m_words[k] = req_wdata[k*32 +: 32];
                if (m_lk) m_cl = 1; else begin m_cl = 0; m_lk = req_atomic; end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, nm, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        string st_tag;
        if (!rst_n) st_tag = "R9";
        else if (m_st == 3) st_tag = "R2";
        else if (m_st == 4) st_tag = "R4";
        else if (m_st == 5) st_tag = "R7";
        else st_tag = "R1";
        chk(st_tag, "bus_state", 32'(bus_state), m_st);
        chk(!rst_n ? "R9" : (hold ? "R7" : "R8"), "holda", 32'(holda), 32'(m_ha));
        chk("R7", "ctl_oe", 32'(ctl_oe), 32'(m_coe));
        chk("R5", "blast_n", 32'(blast_n), 32'(m_bl_n));
        chk("R6", "lock_n", 32'(lock_n), 32'(!m_lk));
        chk("R10", "ad_oe", 32'(ad_oe), 32'(m_aoe));
        if (m_aoe) chk("R10", "ad_out", ad_out, m_ad);
        chk("R11", "ads_n", 32'(ads_n), 32'(m_ads_n));
        chk("R11", "req_ack", 32'(req_ack), 32'(m_ack));
        chk("R11", "bus_wr", 32'(bus_wr), 32'(m_wr));
        chk("R3", "rsp_valid", 32'(rsp_valid), 32'(m_rv));
        if (m_rv) chk("R3", "rsp_data", rsp_data, m_rd);
    endtask

    // ---------------- stimulus ----------------
    int wait_cfg = 0, rec_cfg = 0, wcnt = 0, rcnt = 0;
    logic [31:0]  qa [$];
    bit           qw [$];
    bit           qt [$];
    logic [1:0]   ql [$];
    logic [127:0] qd [$];

    task automatic send(input logic [31:0] a, input bit w, input logic [1:0] l, input bit at);
        qa.push_back(a); qw.push_back(w); ql.push_back(l); qt.push_back(at);
        qd.push_back({a ^ 32'h4444_0003, a ^ 32'h3333_0002, a ^ 32'h2222_0001, a ^ 32'h1111_0000});
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            compare_all();
            if (m_st == 2 || m_st == 3) begin
                if (wcnt == wait_cfg) begin rdy_n = 0; wcnt = 0; end
                else begin rdy_n = 1; wcnt++; end
            end else if (m_st == 4) begin
                if (rcnt == rec_cfg) begin rdy_n = 1; rcnt = 0; end
                else begin rdy_n = 0; rcnt++; end
            end else begin
                rdy_n = 1;
            end
            if (req_valid && req_ack) req_valid = 0;
            if (!req_valid && qa.size() > 0) begin
                req_addr = qa.pop_front(); req_write = qw.pop_front();
                req_len = ql.pop_front(); req_atomic = qt.pop_front();
                req_wdata = qd.pop_front(); req_valid = 1;
            end
            ad_in = 32'hA500_0000 | 32'(cyc);
        end
    endtask

    initial begin
        // R9: reset with and without hold
        hold = 1; step(3);
        hold = 0; step(3);
        rst_n = 1; step(2);
        // R1 R3 R4: single read, no waits
        send(32'h0000_1000, 0, 2'd0, 0); step(10);
        // R2 R4 R5: four-word read, two waits per beat, stretched recovery
        wait_cfg = 2; rec_cfg = 2; send(32'h0000_2000, 0, 2'd3, 0); step(30);
        // R10 R11 R4: back-to-back writes, write end goes straight to address
        wait_cfg = 1; send(32'h0000_3000, 1, 2'd2, 0); send(32'h0000_3100, 1, 2'd0, 0); step(25);
        // R6 R7: atomic pair, hold refused until lock released
        wait_cfg = 0; rec_cfg = 1;
        send(32'h0000_4000, 0, 2'd1, 1); send(32'h0000_4000, 1, 2'd1, 0);
        step(3); hold = 1; step(25); hold = 0; step(5);
        // R7 R8: hold from idle with a request waiting, release into address
        hold = 1; step(3); send(32'h0000_5000, 0, 2'd0, 0); step(3); hold = 0; step(10);
        // R7: hold during a burst waits for completed recovery
        wait_cfg = 1; send(32'h0000_6000, 0, 2'd3, 0); step(3); hold = 1; step(20); hold = 0; step(5);
        // R5 R10: long-wait write then a read
        wait_cfg = 3; rec_cfg = 0;
        send(32'h0000_7000, 1, 2'd3, 0); send(32'h0000_7100, 0, 2'd1, 0); step(45);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule